// File: doc/BRIEF.md
# Multi-Convention TDM Frame Timing Generator

This block sits at the edge of a time-slot switch and turns an external bus's frame marker into the timing that the local side of the switch runs on. It is clocked by the 16.384 MHz master clock and watches an 8 kHz active-low frame pulse. The pulse's falling edge marks a frame boundary. A two-bit bus convention select tells the block how long that pulse is meant to stay low: one master cycle (about 61 ns), two cycles (about 122 ns) or four cycles (about 244 ns). The block reports any pulse whose length does not match the selected convention.

A free-running frame position counter, 2048 master cycles long by default, restarts on every detected boundary. The block flags a boundary that does not fall where the counter expected it. The counter's position drives a 4.096 MHz local clock, a four-cycle active-low local frame pulse centred on the boundary, a one-cycle frame-start strobe, and the bit and channel indices that downstream switch logic uses to address its memories. All outputs are registered, and every timing is derived by counting master cycles.

Top module: `tdm_frame_timer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the frame position is FRAME/2. This gives fo_n_o=1, c4_o=1, frame_start_o=0, bit_o=0, chan_o=CH_PER_FRAME/2, slip_o=0 and width_err_o=0.
- R2: A boundary is the first rising clock edge at which fp_n_i is sampled low after being sampled high. The frame position becomes 0, and frame_start_o is 1, in the second cycle after that edge, whatever the previous position was.
- R3: Without a boundary, the position counts 0 to FRAME-1 and wraps, where FRAME = CYC_PER_BIT*BITS_PER_CH*CH_PER_FRAME. frame_start_o is 1 only at position 0, for a single cycle.
- R4: At each boundary, slip_o is set to 1 if the counter was not at position FRAME-1 in the cycle the edge was seen, and to 0 if it was. Between boundaries slip_o holds its value.
- R5: When a low pulse on fp_n_i ends, width_err_o is set to 1 if the number of low samples differs from the width expected for mode_i, and to 0 otherwise. Between pulses it holds its value. The expected widths are: mode_i 0 expects 1, mode 1 expects 2, mode 2 expects 4, and mode 3 expects 1.
- R6: fo_n_o is 0 exactly at positions FRAME-2, FRAME-1, 0 and 1. This is four consecutive cycles around each boundary.
- R7: c4_o is 1 at positions p with p mod 4 in {0,1} and 0 otherwise, giving a period of four master cycles.
- R8: bit_o equals (p / CYC_PER_BIT) mod BITS_PER_CH, and chan_o equals p / (CYC_PER_BIT*BITS_PER_CH), where p is the current position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16.384 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_n_i | input | 1 | External 8 kHz frame pulse, active low |
| mode_i | input | 2 | Bus convention select (0: 1-cycle pulse, 1: 2-cycle, 2: 4-cycle, 3: 1-cycle) |
| c4_o | output | 1 | 4.096 MHz local clock |
| fo_n_o | output | 1 | Local frame pulse, active low, 4 cycles wide |
| frame_start_o | output | 1 | One-cycle strobe at frame position 0 |
| bit_o | output | $clog2(BITS_PER_CH) | Bit index within the current channel |
| chan_o | output | $clog2(CH_PER_FRAME) | Channel index within the frame |
| slip_o | output | 1 | Last boundary arrived away from the expected position |
| width_err_o | output | 1 | Last frame pulse had the wrong width for the selected mode |

## Verification
The assertions assume that fp_n_i is synchronous to the master clock. They also assume that two falling edges are separated by at least a few cycles, so that one boundary's resync settles before the next, and that mode_i does not change while a pulse is low. The stimulus drives fp_n_i and mode_i only on falling clock edges. It keeps pulse widths between one and five cycles, changes mode only while fp_n_i is high, and places each pulse either exactly one frame after the last start or half a frame away from it. This covers both the aligned and the misplaced boundary in every convention.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;

    typedef enum logic [1:0] {
        BUS_NARROW = 2'd0,
        BUS_DOUBLE = 2'd1,
        BUS_QUAD   = 2'd2,
        BUS_SPARE  = 2'd3
    } bus_mode_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } fp_edges_t;

    typedef struct packed {
        logic frame_start;
        logic fo_n;
        logic c4;
    } loc_out_t;

    localparam int RUN_W = 3;

    function automatic logic [RUN_W-1:0] exp_low_cycles(bus_mode_e m);
        case (m)
            BUS_DOUBLE: return 3'd2;
            BUS_QUAD:   return 3'd4;
            default:    return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/tdm_fp_sampler.sv
module tdm_fp_sampler
    import tdm_timing_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fp_n_i,
    input  bus_mode_e mode_i,
    output fp_edges_t edges_o,
    output logic      width_err_o
);

    logic             fp_s;
    logic             fp_d;
    logic [RUN_W-1:0] low_run;

    always_comb begin
        edges_o.fall = fp_d & ~fp_s;
        edges_o.rise = ~fp_d & fp_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fp_s        <= 1'b1;
            fp_d        <= 1'b1;
            low_run     <= '0;
            width_err_o <= 1'b0;
        end else begin
            fp_s <= fp_n_i;
            fp_d <= fp_s;
            if (!fp_s)
                low_run <= (low_run == '1) ? low_run : low_run + 1'b1;
            else
                low_run <= '0;
            if (edges_o.rise)
                width_err_o <= (low_run != exp_low_cycles(mode_i));
        end
    end

    // R5
    werr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !edges_o.rise |=> $stable(width_err_o));

    // R5
    run_seen_chk: assert property (@(posedge clk) disable iff (rst)
        edges_o.rise |-> (low_run != '0));

endmodule

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
    parameter int FRAME = 2048,
    parameter int CW    = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fall_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] nxt_o,
    output logic          slip_o
);

    localparam logic [CW-1:0] LAST      = CW'(FRAME - 1);
    localparam logic [CW-1:0] RESET_POS = CW'(FRAME / 2);

    always_comb begin
        if (fall_i || cnt_o == LAST)
            nxt_o = '0;
        else
            nxt_o = cnt_o + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o  <= RESET_POS;
            slip_o <= 1'b0;
        end else begin
            cnt_o <= nxt_o;
            if (fall_i)
                slip_o <= (cnt_o != LAST);
        end
    end

    // R2
    resync_chk: assert property (@(posedge clk) disable iff (rst)
        fall_i |=> (cnt_o == '0));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!fall_i && cnt_o == LAST) |=> (cnt_o == '0));

    // R4
    slip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fall_i |=> $stable(slip_o));

endmodule

// File: rtl/tdm_local_out.sv
module tdm_local_out
    import tdm_timing_pkg::*;
#(
    parameter int FRAME = 2048,
    parameter int CW    = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] nxt_i,
    output loc_out_t      out_o
);

    localparam logic [CW-1:0] RESET_POS = CW'(FRAME / 2);

    function automatic loc_out_t decode(logic [CW-1:0] p);
        loc_out_t r;
        r.frame_start = (p == '0);
        r.fo_n        = !((p >= CW'(FRAME - 2)) || (p <= CW'(1)));
        r.c4          = ~p[1];
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst)
            out_o <= decode(RESET_POS);
        else
            out_o <= decode(nxt_i);
    end

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        out_o.frame_start |=> !out_o.frame_start);

    // R6
    start_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_o.frame_start |-> !out_o.fo_n);

    // R7
    c4_high_two_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_o.c4) |=> out_o.c4);

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_timing_pkg::*;
#(
    parameter int CYC_PER_BIT  = 8,
    parameter int BITS_PER_CH  = 8,
    parameter int CH_PER_FRAME = 32,
    localparam int DW    = $clog2(CYC_PER_BIT),
    localparam int BW    = $clog2(BITS_PER_CH),
    localparam int CHW   = $clog2(CH_PER_FRAME),
    localparam int CW    = DW + BW + CHW,
    localparam int FRAME = CYC_PER_BIT * BITS_PER_CH * CH_PER_FRAME
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fp_n_i,
    input  logic [1:0]     mode_i,
    output logic           c4_o,
    output logic           fo_n_o,
    output logic           frame_start_o,
    output logic [BW-1:0]  bit_o,
    output logic [CHW-1:0] chan_o,
    output logic           slip_o,
    output logic           width_err_o
);

    fp_edges_t     edges;
    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;
    loc_out_t      loc;

    tdm_fp_sampler u_sampler (
        .clk         (clk),
        .rst         (rst),
        .fp_n_i      (fp_n_i),
        .mode_i      (bus_mode_e'(mode_i)),
        .edges_o     (edges),
        .width_err_o (width_err_o)
    );

    tdm_frame_counter #(.FRAME(FRAME), .CW(CW)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .fall_i (edges.fall),
        .cnt_o  (cnt),
        .nxt_o  (nxt),
        .slip_o (slip_o)
    );

    tdm_local_out #(.FRAME(FRAME), .CW(CW)) u_out (
        .clk   (clk),
        .rst   (rst),
        .nxt_i (nxt),
        .out_o (loc)
    );

    assign c4_o          = loc.c4;
    assign fo_n_o        = loc.fo_n;
    assign frame_start_o = loc.frame_start;
    assign bit_o         = cnt[DW +: BW];
    assign chan_o        = cnt[DW + BW +: CHW];

endmodule

// File: tb/tdm_frame_timer_bench.sv
module tdm_frame_timer_bench;

    localparam int CPB   = 8;
    localparam int BPC   = 8;
    localparam int CHN   = 4;
    localparam int FRAME = CPB * BPC * CHN;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fp_n = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       c4, fo_n, fstart, slip, werr;
    logic [2:0] bit_idx;
    logic [1:0] chan;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    tdm_frame_timer #(.CYC_PER_BIT(CPB), .BITS_PER_CH(BPC), .CH_PER_FRAME(CHN)) u_tdm_frame_timer (
        .clk           (clk),
        .rst           (rst),
        .fp_n_i        (fp_n),
        .mode_i        (mode),
        .c4_o          (c4),
        .fo_n_o        (fo_n),
        .frame_start_o (fstart),
        .bit_o         (bit_idx),
        .chan_o        (chan),
        .slip_o        (slip),
        .width_err_o   (werr)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_width(int m);
        case (m)
            1: return 2;
            2: return 4;
            default: return 1;
        endcase
    endfunction

    task automatic wait_start();
        @(negedge clk);
        while (!fstart) @(negedge clk);
    endtask

    // Called at a falling edge; drives a low pulse of w cycles.
    task automatic send_pulse(int w, int exp_slip, int exp_werr);
        fp_n = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == w) fp_n = 1'b1;
            if (i == 2) begin
                chk("R2 frame_start after boundary", int'(fstart), 1);
                chk("R4 slip flag", int'(slip), exp_slip);
            end
        end
        chk("R5 width check", int'(werr), exp_werr);
    endtask

    task automatic aligned_pulse(int w, int exp_werr);
        wait_start();
        repeat (FRAME - 2) @(negedge clk);
        send_pulse(w, 0, exp_werr);
    endtask

    task automatic check_frame();
        wait_start();
        for (int j = 0; j < FRAME; j++) begin
            chk("R3 frame_start position", int'(fstart), (j == 0) ? 1 : 0);
            chk("R6 local frame pulse", int'(fo_n), (j <= 1 || j >= FRAME - 2) ? 0 : 1);
            chk("R7 local clock", int'(c4), ((j % 4) < 2) ? 1 : 0);
            chk("R8 bit index", int'(bit_idx), (j / CPB) % BPC);
            chk("R8 channel index", int'(chan), j / (CPB * BPC));
            @(negedge clk);
        end
        chk("R3 frame period", int'(fstart), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset fo_n", int'(fo_n), 1);
        chk("R1 reset c4", int'(c4), 1);
        chk("R1 reset frame_start", int'(fstart), 0);
        chk("R1 reset bit", int'(bit_idx), 0);
        chk("R1 reset chan", int'(chan), CHN / 2);
        chk("R1 reset slip", int'(slip), 0);
        chk("R1 reset width_err", int'(werr), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle chan", int'(chan), CHN / 2);

        for (int m = 0; m < 4; m++) begin
            int w;
            int wbad;
            mode = 2'(m);
            w = exp_width(m);
            wbad = w + 1;
            // misplaced boundary: half a frame after a start
            wait_start();
            repeat (FRAME / 2) @(negedge clk);
            send_pulse(w, 1, 0);
            // aligned boundary with correct width
            aligned_pulse(w, 0);
            check_frame();
            // aligned boundary with wrong width
            aligned_pulse(wbad, 1);
            // correct width clears the flag
            aligned_pulse(w, 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule